// File: doc/BRIEF.md
# Pipelined Bus Wait-State Generator

This block sits on the memory side of a pipelined processor bus, where the processor puts out the request, its kind and its address one bus cycle before the data moves. The controller takes each request at the rising edge that ends the current bus cycle. The following bus cycle becomes that access's data phase. The controller then stretches the data phase by driving an active-low wait line. Each phase lasts a programmable number of whole clock cycles. Nonsequential and sequential accesses each have their own count.

The wait line is launched from the falling clock edge, so it only ever moves while the clock is low. A new request can arrive while a data phase is still being stretched. The controller then holds that request in a one-entry pending slot. The request's own wait count starts only when the current phase completes, even if the processor has since withdrawn the request. One clock after each real data phase completes, a one-clock data-valid strobe goes out to the memory model, together with that phase's address.

Top module: `bus_wait_gen`

## Requirements
- R1: A bus cycle ends at a rising edge where `wait_n` is high. If that cycle was the data phase of an access, `data_valid` is high for exactly the following clock, and `data_addr` then carries that access's address. `data_valid` is never high after an edge where `wait_n` was low.
- R2: An access with `req_seq`=0 (nonsequential) holds `wait_n` low at exactly `cfg_nseq_wait` consecutive rising edges. An access with `req_seq`=1 (sequential) does so at exactly `cfg_seq_wait` edges.
- R3: Once out of reset, `wait_n` changes only while `clk` is low.
- R4: A request is taken at the completing edge of the current bus cycle, and its data phase is the bus cycle that follows. Data phases complete in the order the requests were taken.
- R5: A request seen at a rising edge inside a stretched phase is held. Its data phase follows the current one, even if `req_valid` drops before the current phase completes.
- R6: A wait count of zero leaves `wait_n` high, so accesses presented back to back each complete in one clock.
- R7: A bus cycle with no request (idle) never drives `wait_n` low and never raises `data_valid`.
- R8: While `rst_n` is low, `wait_n` is high and `data_valid` is low. A request held in the pending slot when reset is asserted is discarded.
- R9: The largest count, 2^CW-1, is honoured in full. There is no cap on how long `wait_n` stays low.
- R10: The wait count is sampled at the edge that starts the data phase. Changing `cfg_nseq_wait` or `cfg_seq_wait` during the phase does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Memory request for the next bus cycle |
| req_seq | input | 1 | Request kind: 1 sequential, 0 nonsequential |
| req_addr | input | AW | Address of the next access |
| cfg_nseq_wait | input | CW | Wait states for nonsequential accesses |
| cfg_seq_wait | input | CW | Wait states for sequential accesses |
| wait_n | output | 1 | Active-low wait, launched on the falling edge |
| data_valid | output | 1 | One-clock strobe after a data phase completes |
| data_addr | output | AW | Address of the completed data phase |

## Verification
The embedded assertions check four properties on every cycle. `wait_n` moves only during the low clock phase. No strobe follows an edge where `wait_n` was low. An idle phase never waits. A held pending request stays unchanged until its phase begins. The exact number of wait states, their choice by access kind, and ordering across a held request depend on the stimulus, so the bench's scenarios show them. The same applies to a count changing mid-phase, the full-range count and discarding a pending request on reset.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  typedef enum logic {
    ACC_NSEQ = 1'b0,
    ACC_SEQ  = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/bwg_pend_latch.sv
// One-entry slot for a request that arrives while a data phase is stretched.
module bwg_pend_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          req_valid,
  input  logic          req_seq,
  input  logic [AW-1:0] req_addr,
  output logic          take,
  output logic          take_seq,
  output logic [AW-1:0] take_addr
);
  logic          hold_vld_q, hold_vld_d;
  logic          hold_seq_q;
  logic [AW-1:0] hold_addr_q;
  logic          cap_en;

  // A request becomes a data phase only at a completing edge.
  always_comb begin
    take      = done & (hold_vld_q | req_valid);
    take_seq  = hold_vld_q ? hold_seq_q  : req_seq;
    take_addr = hold_vld_q ? hold_addr_q : req_addr;
    cap_en    = ~done & req_valid & ~hold_vld_q;
    if (done)        hold_vld_d = 1'b0;
    else if (cap_en) hold_vld_d = 1'b1;
    else             hold_vld_d = hold_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_vld_q <= 1'b0;
    else        hold_vld_q <= hold_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_seq_q  <= 1'b0;
      hold_addr_q <= '0;
    end else if (cap_en) begin
      hold_seq_q  <= req_seq;
      hold_addr_q <= req_addr;
    end
  end

  // R5: a held request survives untouched until its phase starts
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld_q && !done) |=> (hold_vld_q && $stable(hold_addr_q) && $stable(hold_seq_q)))
    else $error("held request changed before its phase began");
endmodule

// File: rtl/bwg_wait_cnt.sv
// Wait-state counter on the rising edge, wait launch on the falling edge.
module bwg_wait_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          wait_n_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wait_q, wait_d;

  always_comb begin
    if (load)         cnt_d = load_val;
    else if (!wait_q) cnt_d = cnt_q - 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb wait_d = (cnt_q == '0);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b1;
    else        wait_q <= wait_d;
  end

  assign wait_n_o = wait_q;

  // R2: the last wait state is followed by exactly one high sample
  assert_last_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_q && cnt_q == CW'(1)) |=> wait_q)
    else $error("wait held past its count");

  // R3: wait only moves while the clock is low
  always @(wait_q) begin
    if (rst_n === 1'b1) begin
      assert_fall_launch_R3: assert (clk === 1'b0)
        else $error("wait changed during high clock phase");
    end
  end
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_seq,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] cfg_nseq_wait,
  input  logic [CW-1:0] cfg_seq_wait,
  output logic          wait_n,
  output logic          data_valid,
  output logic [AW-1:0] data_addr
);
  import bwg_pkg::*;

  logic          done;
  logic          take, take_seq;
  logic [AW-1:0] take_addr;
  acc_kind_e     kind;
  logic [CW-1:0] phase_wait;
  logic          act_q, act_d;
  logic [AW-1:0] ph_addr_q, ph_addr_d;
  logic          dv_q, dv_d;
  logic [AW-1:0] daddr_q, daddr_d;

  assign done = wait_n;

  bwg_pend_latch #(.AW(AW)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .req_valid (req_valid),
    .req_seq   (req_seq),
    .req_addr  (req_addr),
    .take      (take),
    .take_seq  (take_seq),
    .take_addr (take_addr)
  );

  always_comb begin
    kind       = acc_kind_e'(take_seq);
    phase_wait = '0;
    if (take) phase_wait = (kind == ACC_SEQ) ? cfg_seq_wait : cfg_nseq_wait;
  end

  bwg_wait_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (done),
    .load_val (phase_wait),
    .wait_n_o (wait_n)
  );

  always_comb begin
    act_d     = done ? take      : act_q;
    ph_addr_d = done ? take_addr : ph_addr_q;
    dv_d      = done & act_q;
    daddr_d   = (done & act_q) ? ph_addr_q : daddr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      ph_addr_q <= '0;
      dv_q      <= 1'b0;
      daddr_q   <= '0;
    end else begin
      act_q     <= act_d;
      ph_addr_q <= ph_addr_d;
      dv_q      <= dv_d;
      daddr_q   <= daddr_d;
    end
  end

  assign data_valid = dv_q;
  assign data_addr  = daddr_q;

  // R1: a stretched edge never yields a strobe
  assert_no_early_dv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n) |=> !data_valid)
    else $error("strobe after a wait edge");

  // R1: every strobe follows a completing edge
  assert_dv_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(wait_n))
    else $error("strobe without completion");

  // R7: idle phases never wait
  assert_idle_nowait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q) |-> wait_n)
    else $error("wait during idle cycle");
endmodule

// File: tb/sim_bus_wait_gen.sv
`timescale 1ns/1ps
module sim_bus_wait_gen;
  localparam int AW = 16;
  localparam int CW = 4;

  typedef struct {
    logic [AW-1:0] addr;
    int            waits;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_seq;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] cfg_n, cfg_s;
  logic          wait_n, data_valid;
  logic [AW-1:0] data_addr;

  int   total = 0;
  int   bad   = 0;
  bit   ended = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  bus_wait_gen #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seq(req_seq),
    .req_addr(req_addr), .cfg_nseq_wait(cfg_n), .cfg_seq_wait(cfg_s),
    .wait_n(wait_n), .data_valid(data_valid), .data_addr(data_addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Driver: present a request and hold it until the edge that takes it.
  task automatic do_access(input logic [AW-1:0] a, input logic s);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_seq = s; req_addr = a;
    e.addr = a; e.waits = s ? int'(cfg_s) : int'(cfg_n);
    sb.push_back(e);
    do @(posedge clk); while (!wait_n);
  endtask

  // Driver: one-clock request pulse, used only inside a stretched phase.
  task automatic pulse_req(input logic [AW-1:0] a, input logic s);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_seq = s; req_addr = a;
    e.addr = a; e.waits = s ? int'(cfg_s) : int'(cfg_n);
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  // Monitor: count low samples per bus cycle, compare at each completion.
  int lows = 0;
  always @(posedge clk) begin
    if (rst_n !== 1'b1) begin
      lows = 0;
    end else if (!wait_n) begin
      lows++;
      #1;
      check(!data_valid, "R1 strobe after wait edge", int'(data_valid), 0);
    end else begin
      int   fin;
      exp_t e;
      fin  = lows;
      lows = 0;
      #1;
      if (data_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1/R8 unexpected strobe", int'(data_addr), -1);
        end else begin
          e = sb.pop_front();
          check(data_addr == e.addr, "R1/R4 address order", int'(data_addr), int'(e.addr));
          check(fin == e.waits, "R2/R6/R9/R10 wait count", fin, e.waits);
        end
      end else begin
        check(fin == 0, "R7 idle cycle waited", fin, 0);
      end
    end
  end

  // R3: wait may only move with the clock low
  always @(wait_n) begin
    if (rst_n === 1'b1 && $time > 0) check(clk === 1'b0, "R3 wait moved with clk high", int'(clk), 0);
  end

  initial begin
    #(200000 * 5);
    if (!ended) begin
      ended = 1;
      check(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_seq = 1'b0; req_addr = '0;
    cfg_n = 4'd3; cfg_s = 4'd1;
    repeat (3) @(posedge clk);
    #1;
    check(wait_n == 1'b1, "R8 reset wait high", int'(wait_n), 1);
    check(data_valid == 1'b0, "R8 reset strobe low", int'(data_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R2: nonsequential then sequential counts
    do_access(16'h1000, 1'b0);
    do_access(16'h1004, 1'b1);
    do_access(16'h1008, 1'b1);
    do_access(16'h2000, 1'b0);
    idle(10);

    // R6: zero waits, back to back
    cfg_n = 4'd0; cfg_s = 4'd0;
    for (int i = 0; i < 4; i++) do_access(16'h3000 + 16'(i * 4), i[0]);
    idle(4);

    // R5: request pulsed during a stretch, then withdrawn
    cfg_n = 4'd4; cfg_s = 4'd2;
    do_access(16'h4000, 1'b0);
    pulse_req(16'h5550, 1'b1);
    idle(20);

    // R10: count changed mid-phase
    cfg_n = 4'd5;
    do_access(16'h6000, 1'b0);
    @(negedge clk); req_valid = 1'b0; cfg_n = 4'd1;
    idle(12);
    cfg_n = 4'd3;

    // R9: full-range count
    cfg_n = 4'd15;
    do_access(16'h7000, 1'b0);
    idle(24);

    // R8: reset discards the pending request
    cfg_n = 4'd6;
    do_access(16'h8000, 1'b0);
    pulse_req(16'h8888, 1'b0);
    @(negedge clk); rst_n = 1'b0; sb.delete();
    repeat (2) @(posedge clk);
    #1;
    check(wait_n == 1'b1, "R8 wait high in reset", int'(wait_n), 1);
    check(data_valid == 1'b0, "R8 strobe low in reset", int'(data_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(12);
    check(sb.size() == 0, "R8 pending discarded", sb.size(), 0);

    // R4: pipelined mix after reset
    cfg_n = 4'd2; cfg_s = 4'd1;
    do_access(16'h9000, 1'b0);
    do_access(16'h9004, 1'b1);
    do_access(16'hA000, 1'b0);
    idle(30);
    check(sb.size() == 0, "R1/R4 all phases completed", sb.size(), 0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule